// File: doc/BRIEF.md
# Branch and Loop-Branch Target Unit

This unit resolves the control-flow outcome of one branch-class instruction per clock. It accepts the fetched instruction word, the program counter already advanced past that instruction, the four condition flags (negative, zero, overflow, carry) and the value read from a register. One cycle later it presents a registered result: whether control transfers, the address to fetch next, and, for the loop form, a register write-back.

Two instruction shapes are recognised. A conditional branch carries a condition selector and a signed 8-bit displacement counted in 16-bit words. A loop branch names a register and carries an unsigned 6-bit backward displacement. The loop branch lowers the register by one, always writes the new value back, and jumps backward while that value is nonzero. Any other word is passed through as a plain fall-through with no write-back. Flag generation and fetch sequencing belong to neighbouring blocks.

Top module: `branch_target_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next state has `valid_o`, `taken_o` and `wb_en_o` at 0, and `next_pc_o`, `wb_sel_o` and `wb_data_o` at 0.
- R2: A word with bits [15:12] = 0 and bits [11:8] in 0..14 is a conditional branch. When it is taken, `next_pc_o` = `pc_i` + 2 × sign-extended bits [7:0]. This reaches +128 to −127 words from the branch's own location.
- R3: The condition selector in bits [11:8] encodes these tests. 0 means always. 1 is Z and 2 is !Z. 3 is N and 4 is !N. 5 is V and 6 is !V. 7 is C and 8 is !C. 9 is N==V and 10 is N!=V. 11 is !Z && N==V and 12 is Z || N!=V. 13 is !C && !Z and 14 is C || Z.
- R4: Whenever a valid instruction is not taken, `next_pc_o` equals the `pc_i` that came with it.
- R5: A word with bits [15:9] = 7'b1000000 is a loop branch. Bits [8:6] name the register and bits [5:0] give the backward offset. The unit drives `wb_en_o` = 1, `wb_sel_o` = bits [8:6] and `wb_data_o` = `reg_val_i` − 1, taken or not.
- R6: A loop branch is taken exactly when `reg_val_i` − 1 is nonzero. Its target is `pc_i` − 2 × bits [5:0].
- R7: At the loop's count boundaries, `reg_val_i` = 1 falls through and writes back 0. `reg_val_i` = 0 wraps to all ones and is taken.
- R8: Every other word, including selector 15 under bits [15:12] = 0, gives `taken_o` = 0 and `wb_en_o` = 0, with `next_pc_o` = `pc_i`.
- R9: Results appear on the clock edge after the one that samples `valid_i` = 1. A cycle with `valid_i` = 0 yields `valid_o`, `taken_o` and `wb_en_o` all 0.
- R10: Target arithmetic wraps modulo 2^W, where W is the PC and data width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Instruction and operands present this cycle |
| instr_i | input | 16 | Fetched instruction word |
| pc_i | input | W | PC already advanced past the instruction |
| flag_n_i | input | 1 | Negative flag |
| flag_z_i | input | 1 | Zero flag |
| flag_v_i | input | 1 | Overflow flag |
| flag_c_i | input | 1 | Carry flag |
| reg_val_i | input | W | Value of the register named by a loop branch |
| valid_o | output | 1 | Registered result is valid |
| taken_o | output | 1 | Control transfers to `next_pc_o` |
| next_pc_o | output | W | Address to fetch next |
| wb_en_o | output | 1 | Register write-back enable |
| wb_sel_o | output | 3 | Register index to write |
| wb_data_o | output | W | Value to write |

## Verification
The loop branch produces a register write-back and a branch decision in the same cycle. Both come from one subtraction, so a fault in the decrement can hide behind a plausible target or the reverse. The bench drives loop branches across counts of 0, 1, 2 and larger values with offsets from 0 to 63. Each cycle it compares the write-back value, the taken bit and the target against a model that derives all three independently. Conditional branches are swept over every selector and all sixteen flag combinations, and back-to-back issue interleaves the two forms so that a stale write-back enable would show up.

// File: rtl/bru_pkg.sv
// Package: shared encodings for the branch/loop-branch target unit.
// Assumes a 16-bit instruction word; field positions are fixed by the format.
package bru_pkg;

    typedef enum logic [3:0] {
        CND_ALWAYS = 4'd0,
        CND_EQ     = 4'd1,
        CND_NE     = 4'd2,
        CND_MI     = 4'd3,
        CND_PL     = 4'd4,
        CND_VS     = 4'd5,
        CND_VC     = 4'd6,
        CND_CS     = 4'd7,
        CND_CC     = 4'd8,
        CND_GE     = 4'd9,
        CND_LT     = 4'd10,
        CND_GT     = 4'd11,
        CND_LE     = 4'd12,
        CND_HI     = 4'd13,
        CND_LOS    = 4'd14,
        CND_RSVD   = 4'd15
    } cond_e;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_COND = 2'd1,
        KIND_LOOP = 2'd2
    } kind_e;

    localparam int INSN_W    = 16;
    localparam int BOFF_W    = 8;
    localparam int LOFF_W    = 6;
    localparam int RSEL_W    = 3;
    localparam logic [3:0] COND_MAJOR = 4'h0;
    localparam logic [6:0] LOOP_MAJOR = 7'b1000000;

    typedef struct packed {
        kind_e                   kind;
        cond_e                   cond;
        logic [BOFF_W-1:0]       boff;
        logic [LOFF_W-1:0]       loff;
        logic [RSEL_W-1:0]       rsel;
    } dec_t;

endpackage

// File: rtl/bru_decode.sv
// Module: bru_decode
// Classifies an instruction word as conditional branch, loop branch or other,
// and extracts the condition selector, offsets and register index.
// Assumes: selector 15 in the conditional space is reserved (treated as other).
module bru_decode
    import bru_pkg::*;
(
    input  logic [INSN_W-1:0] instr_i,
    output dec_t              dec_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int MAJ_HI = INSN_W - 1;

    logic is_cond_space;
    logic is_loop_space;

    // Match the major opcode groups.
    always_comb begin
        is_cond_space = (instr_i[MAJ_HI -: 4] == COND_MAJOR)
                        && (instr_i[11:8] != CND_RSVD);
        is_loop_space = (instr_i[MAJ_HI -: 7] == LOOP_MAJOR);
    end

    // Assemble the decoded fields.
    always_comb begin
        dec_o.cond = cond_e'(instr_i[11:8]);
        dec_o.boff = instr_i[BOFF_W-1:0];
        dec_o.loff = instr_i[LOFF_W-1:0];
        dec_o.rsel = instr_i[LOFF_W +: RSEL_W];
        if (is_cond_space)
            dec_o.kind = KIND_COND;
        else if (is_loop_space)
            dec_o.kind = KIND_LOOP;
        else
            dec_o.kind = KIND_NONE;
    end

endmodule

// File: rtl/bru_cond_eval.sv
// Module: bru_cond_eval
// Evaluates a condition selector against the N, Z, V, C flags.
// Assumes: the reserved selector never reaches here as a branch (result 0).
module bru_cond_eval
    import bru_pkg::*;
(
    input  cond_e cond_i,
    input  logic  n_i,
    input  logic  z_i,
    input  logic  v_i,
    input  logic  c_i,
    output logic  pass_o
);
    timeunit 1ns;
    timeprecision 1ps;

    logic sgn_lt;

    // Signed less-than term shared by four selectors.
    always_comb sgn_lt = n_i ^ v_i;

    // Select the test named by the selector.
    always_comb begin
        unique case (cond_i)
            CND_ALWAYS: pass_o = 1'b1;
            CND_EQ:     pass_o = z_i;
            CND_NE:     pass_o = ~z_i;
            CND_MI:     pass_o = n_i;
            CND_PL:     pass_o = ~n_i;
            CND_VS:     pass_o = v_i;
            CND_VC:     pass_o = ~v_i;
            CND_CS:     pass_o = c_i;
            CND_CC:     pass_o = ~c_i;
            CND_GE:     pass_o = ~sgn_lt;
            CND_LT:     pass_o = sgn_lt;
            CND_GT:     pass_o = ~(z_i | sgn_lt);
            CND_LE:     pass_o = z_i | sgn_lt;
            CND_HI:     pass_o = ~(c_i | z_i);
            CND_LOS:    pass_o = c_i | z_i;
            default:    pass_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/bru_target.sv
// Module: bru_target
// Computes the forward/backward branch target, the loop-branch target and the
// decremented register value. Word offsets are scaled to byte addresses.
// Assumes: W >= 9 so the scaled 8-bit displacement fits.
module bru_target
    import bru_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0]      pc_i,
    input  logic [BOFF_W-1:0] boff_i,
    input  logic [LOFF_W-1:0] loff_i,
    input  logic [W-1:0]      reg_val_i,
    output logic [W-1:0]      br_tgt_o,
    output logic [W-1:0]      loop_tgt_o,
    output logic [W-1:0]      dec_val_o,
    output logic              dec_nz_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int BEXT = W - BOFF_W - 1;
    localparam int LEXT = W - LOFF_W - 1;

    logic [W-1:0] bdisp;
    logic [W-1:0] ldisp;

    // Scale word displacements to byte displacements.
    always_comb begin
        bdisp = {{BEXT{boff_i[BOFF_W-1]}}, boff_i, 1'b0};
        ldisp = {{LEXT{1'b0}}, loff_i, 1'b0};
    end

    // Targets wrap modulo 2^W.
    always_comb begin
        br_tgt_o   = pc_i + bdisp;
        loop_tgt_o = pc_i - ldisp;
    end

    // Loop counter decrement and nonzero test.
    always_comb begin
        dec_val_o = reg_val_i - W'(1);
        dec_nz_o  = |dec_val_o;
    end

endmodule

// File: rtl/branch_target_unit.sv
// Module: branch_target_unit (top)
// Resolves one branch-class instruction per cycle and registers the outcome:
// taken flag, next PC and optional loop-counter write-back.
// Assumes: pc_i already points past the instruction; flags are current.
module branch_target_unit
    import bru_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [INSN_W-1:0] instr_i,
    input  logic [W-1:0]      pc_i,
    input  logic              flag_n_i,
    input  logic              flag_z_i,
    input  logic              flag_v_i,
    input  logic              flag_c_i,
    input  logic [W-1:0]      reg_val_i,
    output logic              valid_o,
    output logic              taken_o,
    output logic [W-1:0]      next_pc_o,
    output logic              wb_en_o,
    output logic [RSEL_W-1:0] wb_sel_o,
    output logic [W-1:0]      wb_data_o
);
    timeunit 1ns;
    timeprecision 1ps;

    dec_t         dec;
    logic         cond_pass;
    logic [W-1:0] br_tgt;
    logic [W-1:0] loop_tgt;
    logic [W-1:0] dec_val;
    logic         dec_nz;

    logic         take_d;
    logic [W-1:0] npc_d;
    logic         wen_d;

    bru_decode u_dec (
        .instr_i (instr_i),
        .dec_o   (dec)
    );

    bru_cond_eval u_cond (
        .cond_i (dec.cond),
        .n_i    (flag_n_i),
        .z_i    (flag_z_i),
        .v_i    (flag_v_i),
        .c_i    (flag_c_i),
        .pass_o (cond_pass)
    );

    bru_target #(.W(W)) u_tgt (
        .pc_i       (pc_i),
        .boff_i     (dec.boff),
        .loff_i     (dec.loff),
        .reg_val_i  (reg_val_i),
        .br_tgt_o   (br_tgt),
        .loop_tgt_o (loop_tgt),
        .dec_val_o  (dec_val),
        .dec_nz_o   (dec_nz)
    );

    // Choose the outcome for the decoded instruction kind.
    always_comb begin
        take_d = 1'b0;
        npc_d  = pc_i;
        wen_d  = 1'b0;
        unique case (dec.kind)
            KIND_COND: begin
                take_d = cond_pass;
                if (cond_pass) npc_d = br_tgt;
            end
            KIND_LOOP: begin
                wen_d  = 1'b1;
                take_d = dec_nz;
                if (dec_nz) npc_d = loop_tgt;
            end
            default: ;
        endcase
    end

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o   <= 1'b0;
            taken_o   <= 1'b0;
            next_pc_o <= '0;
            wb_en_o   <= 1'b0;
            wb_sel_o  <= '0;
            wb_data_o <= '0;
        end else begin
            valid_o   <= valid_i;
            taken_o   <= valid_i & take_d;
            next_pc_o <= npc_d;
            wb_en_o   <= valid_i & wen_d;
            wb_sel_o  <= dec.rsel;
            wb_data_o <= dec_val;
        end
    end

    // R9: no activity reported without a valid result.
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (!taken_o && !wb_en_o));

    // R9: one-cycle latency of the valid strobe.
    assert_valid_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o);

    // R4: fall-through keeps the incoming PC.
    assert_fallthrough_pc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !taken_o) |-> (next_pc_o == $past(pc_i)));

    // R5: write-back carries the register value minus one.
    assert_wb_decrement_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o |-> (wb_data_o == W'($past(reg_val_i) - W'(1))));

    // R6: loop branch is taken exactly when the written value is nonzero.
    assert_loop_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o |-> (taken_o == (wb_data_o != '0)));

endmodule

// File: tb/branch_target_unit_test.sv
module branch_target_unit_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int W = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          valid_i = 1'b0;
    logic [15:0]   instr_i = '0;
    logic [W-1:0]  pc_i = '0;
    logic          flag_n_i = 1'b0, flag_z_i = 1'b0, flag_v_i = 1'b0, flag_c_i = 1'b0;
    logic [W-1:0]  reg_val_i = '0;
    logic          valid_o, taken_o, wb_en_o;
    logic [W-1:0]  next_pc_o, wb_data_o;
    logic [2:0]    wb_sel_o;

    branch_target_unit #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .instr_i(instr_i),
        .pc_i(pc_i), .flag_n_i(flag_n_i), .flag_z_i(flag_z_i),
        .flag_v_i(flag_v_i), .flag_c_i(flag_c_i), .reg_val_i(reg_val_i),
        .valid_o(valid_o), .taken_o(taken_o), .next_pc_o(next_pc_o),
        .wb_en_o(wb_en_o), .wb_sel_o(wb_sel_o), .wb_data_o(wb_data_o)
    );

    always #2.5 clk = ~clk;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    typedef struct packed {
        bit        v;
        bit        tk;
        bit [15:0] npc;
        bit        we;
        bit [2:0]  ws;
        bit [15:0] wd;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    function automatic bit cond_ok(int sel, bit n, bit z, bit v, bit c);
        case (sel)
            0: return 1;
            1: return z;
            2: return !z;
            3: return n;
            4: return !n;
            5: return v;
            6: return !v;
            7: return c;
            8: return !c;
            9: return n == v;
            10: return n != v;
            11: return !z && (n == v);
            12: return z || (n != v);
            13: return !c && !z;
            14: return c || z;
            default: return 0;
        endcase
    endfunction

    function automatic exp_t model(bit v, bit [15:0] ins, bit [15:0] pc,
                                   bit [3:0] f, bit [15:0] rs);
        exp_t e;
        int   off;
        int   cnt;
        e.v = v; e.tk = 0; e.npc = pc; e.we = 0;
        e.ws = ins[8:6];
        e.wd = 16'((int'(rs) + 65535) % 65536);
        if (ins[15:12] == 4'h0 && ins[11:8] != 4'hF) begin
            if (cond_ok(int'(ins[11:8]), f[3], f[2], f[1], f[0])) begin
                off = int'(ins[7:0]);
                if (off > 127) off = off - 256;
                e.tk = v;
                e.npc = 16'((int'(pc) + 2 * off + 65536 * 4) % 65536);
            end
        end else if (ins[15:9] == 7'b1000000) begin
            e.we = v;
            cnt = (int'(rs) + 65535) % 65536;
            if (cnt != 0) begin
                e.tk = v;
                e.npc = 16'((int'(pc) - 2 * int'(ins[5:0]) + 65536) % 65536);
            end
        end
        if (!v) begin
            e.tk = 0; e.we = 0;
        end
        return e;
    endfunction

    task automatic compare();
        exp_t  e;
        string t;
        if (exp_q.size() == 0) return;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_vec++;
        if (valid_o !== e.v || taken_o !== e.tk || next_pc_o !== e.npc ||
            wb_en_o !== e.we || (e.we && (wb_sel_o !== e.ws || wb_data_o !== e.wd))) begin
            n_bad++;
            $display("FAIL %s: got v=%0b tk=%0b npc=%h we=%0b ws=%0d wd=%h exp v=%0b tk=%0b npc=%h we=%0b ws=%0d wd=%h",
                     t, valid_o, taken_o, next_pc_o, wb_en_o, wb_sel_o, wb_data_o,
                     e.v, e.tk, e.npc, e.we, e.ws, e.wd);
        end
    endtask

    task automatic apply(bit v, bit [15:0] ins, bit [15:0] pc, bit [3:0] f,
                         bit [15:0] rs, string tag);
        @(negedge clk);
        compare();
        valid_i = v; instr_i = ins; pc_i = pc;
        {flag_n_i, flag_z_i, flag_v_i, flag_c_i} = f;
        reg_val_i = rs;
        exp_q.push_back(model(v, ins, pc, f, rs));
        tag_q.push_back(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout exp completion");
        finish_run();
    end

    initial begin
        // R1: reset state with busy inputs.
        valid_i = 1; instr_i = 16'h8045; reg_val_i = 16'h0005; pc_i = 16'h1234;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_vec++;
        if (valid_o !== 0 || taken_o !== 0 || wb_en_o !== 0 || next_pc_o !== 0 ||
            wb_sel_o !== 0 || wb_data_o !== 0) begin
            n_bad++;
            $display("FAIL R1: got v=%0b tk=%0b we=%0b npc=%h exp all zero",
                     valid_o, taken_o, wb_en_o, next_pc_o);
        end
        valid_i = 0;
        rst_n = 1;

        // R3: every selector against every flag combination.
        for (int s = 0; s < 15; s++)
            for (int f = 0; f < 16; f++)
                apply(1, {4'h0, 4'(s), 8'h10}, 16'h2000, 4'(f), 16'h0, "R3");

        // R2: displacement extremes and signs.
        apply(1, 16'h007F, 16'h1000, 4'h0, 16'h0, "R2");
        apply(1, 16'h0080, 16'h1000, 4'h0, 16'h0, "R2");
        apply(1, 16'h00FF, 16'h1000, 4'h0, 16'h0, "R2");
        apply(1, 16'h0100, 16'h1000, 4'h4, 16'h0, "R2");
        // R4: not-taken fall-through.
        apply(1, 16'h0155, 16'h3332, 4'h0, 16'h0, "R4");
        apply(1, 16'h0E7F, 16'h4444, 4'h0, 16'h0, "R4");
        // R10: wrap both ways.
        apply(1, 16'h0070, 16'hFFF0, 4'h0, 16'h0, "R10");
        apply(1, 16'h0090, 16'h0010, 4'h0, 16'h0, "R10");
        apply(1, 16'h803F, 16'h0010, 4'h0, 16'h0009, "R10");

        // R5/R6/R7: loop branch across counts and registers.
        for (int r = 0; r < 8; r++)
            apply(1, {7'b1000000, 3'(r), 6'(r * 9)}, 16'h5000, 4'hF, 16'(r + 3), "R5");
        apply(1, 16'h8000, 16'h6000, 4'h0, 16'h0002, "R6");
        apply(1, 16'h807F, 16'h6000, 4'h0, 16'h0040, "R6");
        apply(1, 16'h8105, 16'h6000, 4'h0, 16'h0001, "R7");
        apply(1, 16'h8105, 16'h6000, 4'h0, 16'h0000, "R7");

        // R8: words outside both groups.
        apply(1, 16'h0F05, 16'h7000, 4'h0, 16'h0003, "R8");
        apply(1, 16'h8240, 16'h7000, 4'h0, 16'h0003, "R8");
        apply(1, 16'h1234, 16'h7000, 4'h0, 16'h0003, "R8");
        apply(1, 16'hF500, 16'h7000, 4'h0, 16'h0003, "R8");

        // R9: idle cycles carrying branch-looking words.
        apply(0, 16'h0010, 16'h7100, 4'h0, 16'h0003, "R9");
        apply(0, 16'h8045, 16'h7100, 4'h0, 16'h0005, "R9");
        apply(1, 16'h8045, 16'h7100, 4'h0, 16'h0005, "R9");
        apply(0, 16'h8045, 16'h7100, 4'h0, 16'h0005, "R9");

        // Mixed back-to-back stream.
        for (int i = 0; i < 3000; i++) begin
            bit [15:0] ins;
            bit [31:0] rnd = $urandom;
            case (rnd[1:0])
                2'd0: ins = {4'h0, 4'(rnd[7:4]), 8'(rnd[15:8])};
                2'd1: ins = {7'b1000000, 9'(rnd[24:16])};
                2'd2: ins = 16'($urandom);
                default: ins = {4'h0, 4'(rnd[7:4] % 15), 8'(rnd[15:8])};
            endcase
            apply(rnd[2] | rnd[3], ins, 16'($urandom) & 16'hFFFE, 4'(rnd[31:28]),
                  16'($urandom % 4), "R6");
        end

        apply(0, 16'h0, 16'h0, 4'h0, 16'h0, "R9");
        @(negedge clk);
        compare();
        finish_run();
    end

endmodule